// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags

This block is the arithmetic and logic unit of a small word-oriented minicomputer core. It takes a source operand, a destination operand, a 4-bit operation code and a byte select. It returns the result word and six status bits. The operations are add, subtract, compare, four bitwise functions, move, absolute value, negate and four shifts. Operand fetch, instruction decode, multiply/divide and interrupt masking belong to the surrounding CPU.

The unit is pipelined by one register. A request presented with `valid_i` high is evaluated combinationally and captured at the next rising clock edge. The result and flags then hold until the next request. Byte mode works on the upper half of each operand. The lower half of the destination passes through to the result unchanged, and every flag comes from the byte. The status word the CPU stores is `{flags_o, 10'b0}`, so a mask of >FC00 keeps all the flags.

Top module: `status_alu`

## Requirements
- R1: A request with `valid_i`=1 appears on `res_o`/`flags_o` with `valid_o`=1 one clock later. Without `valid_i`, `valid_o` is 0 and `res_o`/`flags_o` hold their last values.
- R2: `flags_o` bits are [5] logical-greater, [4] arithmetic-greater, [3] equal, [2] carry, [1] overflow, [0] odd parity. With `{flags_o,10'b0}` the overflow bit is >0800. For result-based flags, equal means the result is zero, logical-greater means it is nonzero, and arithmetic-greater means it is positive as a signed value.
- R3: Op 0 (add) gives dst+src. Carry is the carry out. Overflow is set when the src and dst signs are equal and the result sign differs from the dst sign.
- R4: Op 1 (subtract) gives dst−src. Carry means no borrow (dst ≥ src unsigned). Overflow is set when the src and dst signs differ and the result sign differs from the dst sign. For example, (src,dst)=(>8000,>7FFF) sets overflow and (>8000,>FFFF) does not.
- R5: Op 2 (compare) sets logical-greater for src>dst unsigned, arithmetic-greater for src>dst signed, and equal for src==dst. Carry and overflow are 0 and the result is dst.
- R6: Byte mode (`byte_i`=1, ops 0–7) works on bits [15:8] of each operand. Result bits [7:0] equal dst[7:0]. Flags come from the byte, and parity is the odd parity of the result byte. Word operations give parity 0.
- R7: Compare in byte mode takes parity from the source byte, not from the difference.
- R8: Ops 3–7 are dst&src, dst|src, dst&~src, dst^src and move (result = src). Carry and overflow are 0 and the other flags come from the result.
- R9: Op 8 (absolute value) gives |src|. The greater and equal flags compare src with zero. Overflow is set exactly when src is >8000, and carry is 0.
- R10: Op 9 (negate) gives 0−src. Flags come from the result, carry is set when src is 0, and overflow is set when src is >8000.
- R11: Ops 10–13 shift dst (arithmetic left, arithmetic right, logical right, rotate right) by src[3:0] places, where 0 means 16. Carry is the last bit shifted out. For the left shift, overflow is set when the sign bit changes at any step.
- R12: Ops 14 and 15 return dst with all flags 0. `byte_i` has no effect on ops 8–15.
- R13: While reset is asserted, `res_o`, `flags_o` and `valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | Byte mode select |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| res_o | output | 16 | Result |
| flags_o | output | 6 | Status flags |
| valid_o | output | 1 | Result valid |

## Verification
The only state in this block is the output register, so a wrong operand path, flag rule or byte-lane merge shows at the ports one clock after the request that exposes it. The sign-based overflow rules fail only on a narrow set of operand signs. For that reason, operands are biased toward >0000, >7FFF, >8000 and >FFFF, and the specific subtract vectors are run directly. A fault in the parity source for byte compare shows only when the source byte and the difference byte have different parity, so a directed case is built for exactly that.

// File: rtl/status_alu_pkg.sv
package status_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_ANDN = 4'd5,
    OP_XOR  = 4'd6,
    OP_MOV  = 4'd7,
    OP_ABS  = 4'd8,
    OP_NEG  = 4'd9,
    OP_SLA  = 4'd10,
    OP_SRA  = 4'd11,
    OP_SRL  = 4'd12,
    OP_SRC  = 4'd13,
    OP_R14  = 4'd14,
    OP_R15  = 4'd15
  } op_e;

  typedef struct packed {
    logic lgt;
    logic agt;
    logic eq;
    logic cy;
    logic ov;
    logic par;
  } flags_t;
endpackage

// File: rtl/status_alu_arith.sv
module status_alu_arith
  import status_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] sum, dif, neg;
  logic            src_min;

  assign sum     = {1'b0, dst_i} + {1'b0, src_i};
  assign dif     = {1'b0, dst_i} + {1'b0, ~src_i} + (DATA_W+1)'(1);
  assign neg     = {1'b0, ~src_i} + (DATA_W+1)'(1);
  assign src_min = src_i[MSB] & ~|src_i[MSB-1:0];

  function automatic flags_t from_val(logic [DATA_W-1:0] v);
    flags_t f;
    f     = '0;
    f.eq  = ~|v;
    f.lgt = |v;
    f.agt = ~v[MSB] & |v;
    return f;
  endfunction

  always_comb begin
    res_o = dst_i;
    flg_o = '0;
    unique case (op_i)
      OP_ADD: begin
        res_o  = sum[MSB:0];
        flg_o  = from_val(sum[MSB:0]);
        flg_o.cy = sum[DATA_W];
        flg_o.ov = (src_i[MSB] == dst_i[MSB]) && (sum[MSB] != dst_i[MSB]);
      end
      OP_SUB: begin
        res_o  = dif[MSB:0];
        flg_o  = from_val(dif[MSB:0]);
        flg_o.cy = dif[DATA_W];
        flg_o.ov = (src_i[MSB] != dst_i[MSB]) && (dif[MSB] != dst_i[MSB]);
      end
      OP_CMP: begin
        res_o     = dst_i;
        flg_o.eq  = (src_i == dst_i);
        flg_o.lgt = (src_i > dst_i);
        flg_o.agt = ($signed(src_i) > $signed(dst_i));
      end
      OP_ABS: begin
        res_o    = src_i[MSB] ? neg[MSB:0] : src_i;
        flg_o    = from_val(src_i);
        flg_o.ov = src_min;
      end
      OP_NEG: begin
        res_o    = neg[MSB:0];
        flg_o    = from_val(neg[MSB:0]);
        flg_o.cy = ~|src_i;
        flg_o.ov = src_min;
      end
      default: begin
        res_o = dst_i;
        flg_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/status_alu_logic.sv
module status_alu_logic
  import status_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = dst_i & src_i;
      OP_OR:   res_o = dst_i | src_i;
      OP_ANDN: res_o = dst_i & ~src_i;
      OP_XOR:  res_o = dst_i ^ src_i;
      OP_MOV:  res_o = src_i;
      default: res_o = dst_i;
    endcase
    flg_o     = '0;
    flg_o.eq  = ~|res_o;
    flg_o.lgt = |res_o;
    flg_o.agt = ~res_o[MSB] & |res_o;
  end
endmodule

// File: rtl/status_alu_shift.sv
module status_alu_shift
  import status_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o
);
  localparam int MSB   = DATA_W - 1;
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W:0] cnt;

  // a zero count field selects a full-width shift
  assign cnt = (src_i[CNT_W-1:0] == '0) ? (CNT_W+1)'(DATA_W)
                                        : {1'b0, src_i[CNT_W-1:0]};

  always_comb begin
    logic [DATA_W-1:0] v;
    logic              cy, ov;
    v  = dst_i;
    cy = 1'b0;
    ov = 1'b0;
    for (int k = 0; k < DATA_W; k++) begin
      if (k < int'(cnt)) begin
        unique case (op_i)
          OP_SLA: begin
            cy = v[MSB];
            v  = {v[MSB-1:0], 1'b0};
            if (v[MSB] != cy) ov = 1'b1;
          end
          OP_SRA: begin
            cy = v[0];
            v  = {v[MSB], v[MSB:1]};
          end
          OP_SRL: begin
            cy = v[0];
            v  = {1'b0, v[MSB:1]};
          end
          OP_SRC: begin
            cy = v[0];
            v  = {v[0], v[MSB:1]};
          end
          default: ;
        endcase
      end
    end
    res_o     = v;
    flg_o     = '0;
    flg_o.eq  = ~|v;
    flg_o.lgt = |v;
    flg_o.agt = ~v[MSB] & |v;
    flg_o.cy  = cy;
    flg_o.ov  = ov;
  end
endmodule

// File: rtl/status_alu.sv
module status_alu
  import status_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output logic [5:0]        flags_o,
  output logic              valid_o
);
  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  op_e               op;
  logic              lane;
  logic [DATA_W-1:0] s_x, d_x;
  logic [DATA_W-1:0] r_ar, r_lg, r_sh, r_sel, r_fin;
  flags_t            f_ar, f_lg, f_sh, f_sel;
  logic              par;

  assign op   = op_e'(op_i);
  // byte lane only for the two-operand group, codes 0..7
  assign lane = byte_i & ~op_i[3];
  assign s_x  = lane ? {src_i[MSB:HALF], {HALF{1'b0}}} : src_i;
  assign d_x  = lane ? {dst_i[MSB:HALF], {HALF{1'b0}}} : dst_i;

  status_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i (op),
    .src_i(s_x),
    .dst_i(d_x),
    .res_o(r_ar),
    .flg_o(f_ar)
  );

  status_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i (op),
    .src_i(s_x),
    .dst_i(d_x),
    .res_o(r_lg),
    .flg_o(f_lg)
  );

  status_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .op_i (op),
    .src_i(src_i),
    .dst_i(dst_i),
    .res_o(r_sh),
    .flg_o(f_sh)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP, OP_ABS, OP_NEG: begin
        r_sel = r_ar;
        f_sel = f_ar;
      end
      OP_AND, OP_OR, OP_ANDN, OP_XOR, OP_MOV: begin
        r_sel = r_lg;
        f_sel = f_lg;
      end
      OP_SLA, OP_SRA, OP_SRL, OP_SRC: begin
        r_sel = r_sh;
        f_sel = f_sh;
      end
      default: begin
        r_sel = dst_i;
        f_sel = '0;
      end
    endcase
  end

  assign r_fin = lane ? {r_sel[MSB:HALF], dst_i[HALF-1:0]} : r_sel;

  // byte compare uses a second parity tree on the source byte
  always_comb begin
    if (!lane)             par = 1'b0;
    else if (op == OP_CMP) par = ^src_i[MSB:HALF];
    else                   par = ^r_sel[MSB:HALF];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      flags_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o   <= r_fin;
        flags_o <= {f_sel.lgt, f_sel.agt, f_sel.eq, f_sel.cy, f_sel.ov, par};
      end
    end
  end
endmodule

// File: rtl/status_alu_chk.sv
module status_alu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              byte_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] res_o,
  input logic [5:0]        flags_o,
  input logic              valid_o
);
  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o) && $stable(flags_o)));  // R1
  AST_EQ_EXCLUDES_LGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(flags_o[3] && flags_o[5]));  // R2
  AST_SUB_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd1 && !byte_i) |=>
      (flags_o[1] == (($past(src_i[MSB]) != $past(dst_i[MSB])) &&
                      (res_o[MSB] != $past(dst_i[MSB])))));  // R4
  AST_CMP_KEEPS_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd2) |=> (res_o == $past(dst_i) && !flags_o[2] && !flags_o[1]));  // R5
  AST_BYTE_LOW_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && byte_i && !op_i[3]) |=> (res_o[HALF-1:0] == $past(dst_i[HALF-1:0])));  // R6
  AST_WORD_NO_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(byte_i && !op_i[3])) |=> !flags_o[0]);  // R6
  AST_RESERVED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[3:1] == 3'b111) |=> (flags_o == 6'd0 && res_o == $past(dst_i)));  // R12
endmodule

bind status_alu status_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .byte_i (byte_i),
  .src_i  (src_i),
  .dst_i  (dst_i),
  .res_o  (res_o),
  .flags_o(flags_o),
  .valid_o(valid_o)
);

// File: tb/status_alu_test.sv
module status_alu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] src_i = '0;
  logic [15:0] dst_i = '0;
  logic [15:0] res_o;
  logic [5:0]  flags_o;
  logic        valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  status_alu uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .byte_i(byte_i), .src_i(src_i), .dst_i(dst_i),
    .res_o(res_o), .flags_o(flags_o), .valid_o(valid_o)
  );

  function automatic int sgn(int v, int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  // expected {result, lgt, agt, eq, cy, ov, par}
  function automatic logic [21:0] model(logic [3:0] op, logic b, logic [15:0] s, logic [15:0] d);
    bit sb;
    int w, m, sv, dv, r, cnt, hb;
    bit lgt, agt, eq, cy, ov, p, from_r;
    logic [15:0] full;
    logic [7:0]  rb;
    sb = b && op < 4'd8;
    w  = sb ? 8 : 16;
    m  = (1 << w) - 1;
    hb = 1 << (w - 1);
    sv = sb ? int'(s[15:8]) : int'(s);
    dv = sb ? int'(d[15:8]) : int'(d);
    {lgt, agt, eq, cy, ov, p} = '0;
    from_r = 1'b1;
    r = dv;
    case (op)
      4'd0: begin r = sv + dv; cy = r > m; r = r & m;
              ov = ((sv & hb) == (dv & hb)) && ((r & hb) != (dv & hb)); end
      4'd1: begin r = (dv - sv) & m; cy = dv >= sv;
              ov = ((sv & hb) != (dv & hb)) && ((r & hb) != (dv & hb)); end
      4'd2: begin from_r = 1'b0; r = dv; lgt = sv > dv; agt = sgn(sv, w) > sgn(dv, w); eq = sv == dv; end
      4'd3: r = dv & sv;
      4'd4: r = dv | sv;
      4'd5: r = dv & ~sv & m;
      4'd6: r = dv ^ sv;
      4'd7: r = sv;
      4'd8: begin from_r = 1'b0; r = (sgn(sv, 16) < 0) ? (-sv) & m : sv;
              lgt = sv != 0; agt = sgn(sv, 16) > 0; eq = sv == 0; ov = sv == 32'h8000; end
      4'd9: begin r = (-sv) & m; cy = sv == 0; ov = sv == 32'h8000; end
      4'd10, 4'd11, 4'd12, 4'd13: begin
        cnt = (s[3:0] == 4'd0) ? 16 : int'(s[3:0]);
        for (int k = 0; k < cnt; k++) begin
          case (op)
            4'd10: begin cy = r[15]; r = (r << 1) & m; if (r[15] != cy) ov = 1'b1; end
            4'd11: begin cy = r[0]; r = (r >> 1) | (r & 32'h8000); end
            4'd12: begin cy = r[0]; r = r >> 1; end
            default: begin cy = r[0]; r = (r >> 1) | (int'(cy) << 15); end
          endcase
        end
      end
      default: begin from_r = 1'b0; r = int'(d); end
    endcase
    if (from_r) begin
      lgt = r != 0;
      agt = sgn(r, w) > 0;
      eq  = r == 0;
    end
    rb   = r[7:0];
    if (sb) p = (op == 4'd2) ? ^s[15:8] : ^rb;
    full = sb ? {rb, d[7:0]} : 16'(r);
    return {full, lgt, agt, eq, cy, ov, p};
  endfunction

  function automatic string tag_of(logic [3:0] op, logic b);
    if (b && op == 4'd2) return "R7";
    if (b && op < 4'd8)  return "R6";
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      4'd10, 4'd11, 4'd12, 4'd13: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, logic [21:0] got, logic [21:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got res=%h flags=%b, expected res=%h flags=%b",
               tag, got[21:6], got[5:0], exp[21:6], exp[5:0]);
    end
  endtask

  task automatic run(logic [3:0] op, logic b, logic [15:0] s, logic [15:0] d, string tag);
    @(negedge clk_i);
    op_i = op; byte_i = b; src_i = s; dst_i = d; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check(tag, {res_o, flags_o}, model(op, b, s, d));
    n_chk++;
    if (valid_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: valid_o=%b expected 1", valid_o);
    end
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'h0000_5EED));
    #3;
    // R13 reset state
    check("R13", {res_o, flags_o}, 22'd0);
    n_chk++;
    if (valid_o !== 1'b0) begin n_bad++; $display("FAIL R13: valid_o=%b expected 0", valid_o); end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 flag placement: 2-1 -> lgt, agt, carry = >D000
    run(4'd1, 1'b0, 16'h0001, 16'h0002, "R4");
    n_chk++;
    if ({flags_o, 10'b0} !== 16'hD000) begin
      n_bad++; $display("FAIL R2: status=%h expected D000", {flags_o, 10'b0});
    end
    // R4 subtract overflow vectors
    run(4'd1, 1'b0, 16'h7FFF, 16'h0001, "R4");
    run(4'd1, 1'b0, 16'h8000, 16'h7FFF, "R4");
    n_chk++;
    if ({flags_o, 10'b0} & 16'h0800) ; else begin n_bad++; $display("FAIL R2: overflow bit got %h expected 0800", {flags_o,10'b0} & 16'h0800); end
    run(4'd1, 1'b0, 16'h7FFF, 16'h8000, "R4");
    run(4'd1, 1'b0, 16'hFFFF, 16'h8000, "R4");
    run(4'd1, 1'b0, 16'h8000, 16'hFFFF, "R4");
    run(4'd1, 1'b0, 16'h8000, 16'h8000, "R4");
    run(4'd1, 1'b0, 16'h0000, 16'h8000, "R4");
    // R3 add overflow
    run(4'd0, 1'b0, 16'h7FFF, 16'h0001, "R3");
    run(4'd0, 1'b0, 16'h8000, 16'h8000, "R3");
    // R6 byte subtract vectors
    run(4'd1, 1'b1, 16'h8012, 16'h7F34, "R6");
    run(4'd0, 1'b1, 16'h7F00, 16'h01AB, "R6");
    // R7: src byte 07 (odd), difference FA (even)
    run(4'd2, 1'b1, 16'h0700, 16'h0100, "R7");
    n_chk++;
    if (flags_o[0] !== 1'b1) begin n_bad++; $display("FAIL R7: parity=%b expected 1", flags_o[0]); end
    // R5 compare signed vs unsigned
    run(4'd2, 1'b0, 16'h0001, 16'hFFFF, "R5");
    // R9 / R10 minimum value
    run(4'd8, 1'b0, 16'h8000, 16'h1234, "R9");
    run(4'd8, 1'b0, 16'hFFFE, 16'h0000, "R9");
    run(4'd9, 1'b0, 16'h8000, 16'h0000, "R10");
    run(4'd9, 1'b0, 16'h0000, 16'h5555, "R10");
    // R11 count zero means 16, SLA overflow
    run(4'd10, 1'b0, 16'h0000, 16'h4001, "R11");
    run(4'd10, 1'b0, 16'h0001, 16'h4000, "R11");
    run(4'd13, 1'b0, 16'h0004, 16'h0009, "R11");
    // R12 reserved code and byte ignored for word-only ops
    run(4'd14, 1'b1, 16'hAAAA, 16'h1357, "R12");
    run(4'd9, 1'b1, 16'h0100, 16'h00FF, "R12");
    // R8 logic
    run(4'd5, 1'b0, 16'hFF00, 16'hF0F0, "R8");

    // R1 hold while idle
    held = res_o;
    @(negedge clk_i);
    op_i = 4'd0; src_i = 16'h1111; dst_i = 16'h2222;
    @(negedge clk_i);
    n_chk++;
    if (res_o !== held || valid_o !== 1'b0) begin
      n_bad++; $display("FAIL R1: res=%h valid=%b expected res=%h valid=0", res_o, valid_o, held);
    end

    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  op;
      logic        b;
      logic [15:0] s, d;
      op = 4'($urandom);
      b  = 1'($urandom);
      s  = pick();
      d  = pick();
      run(op, b, s, d, tag_of(op, b));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule